// File: doc/BRIEF.md
# Dual Parallel Port I/O Controller

This peripheral gives a host 48 general-purpose pins, arranged as two identical groups of three 8-bit ports named A, B and C. The host reaches it through an eight-byte register window on a simple synchronous bus. The bus has a 3-bit address, separate read and write strobes, an 8-bit write data path and an 8-bit registered read data path. Each pin is presented to the pad ring as three separate signals: an input level, an output level and an output enable.

Each group has one control register. Writing it with the top bit set is a mode-set command, which fixes the direction of the whole group. Ports A and B turn around as whole bytes. Port C turns around per nibble. Every mode-set command also zeroes that group's output latches.

Writing the control register with the top bit clear performs a single-bit set or reset on that group's port C latch. This lets one port C line be toggled without a read-modify-write sequence. Only plain input/output operation is provided.

Top module: `pio_dual`

## Requirements
- R1: After reset, every pin_oe and pin_out bit is 0, and both control registers read back as 0x9B (every field an input).
- R2: Address bit 2 selects the group (0 for group 1 on pins 23:0, 1 for group 2 on pins 47:24). Address bits 1:0 select port A (0, pins +7:+0), port B (1, pins +15:+8), port C (2, pins +23:+16) or the control register (3).
- R3: A control write with bit 7 = 1 sets that group's directions. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 3 = 1 makes port C 7:4 an input, and bit 0 = 1 makes port C 3:0 an input. A 0 in any of these bits makes that field an output, and pin_oe is 1 exactly on output bits.
- R4: A write to a port register loads that port's latch. pin_out always presents the latch contents, whatever the direction.
- R5: The two nibbles of port C take their direction independently, so one nibble can be an input while the other is an output.
- R6: A mode-set write clears all three latches of its own group to 0 and leaves the other group untouched.
- R7: A control write with bit 7 = 0 sets port C latch bit wdata[3:1] of that group to wdata[0]. Every other latch bit, every direction and the control read-back value stay unchanged.
- R8: A port read returns the latch for output bits and pin_in for input bits. A control read returns the last mode-set word written.
- R9: bus_rdata changes only on the clock edge after a sampled bus_rd and otherwise holds its value. A read and a write in the same cycle return the state from before the write.
- R10: A write takes effect on the edge at which bus_wr is sampled. pin_out and pin_oe change only after such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Pin input levels |
| pin_out | output | 48 | Output latch levels |
| pin_oe | output | 48 | Output enables, 1 = drive |

## Verification
A read and a write can land in the same cycle. When they hit the same port, or a port and its group's control register, the read must return the state from before the write. The bench issues such combined strobes on purpose, against data and mode-set words, and checks the value captured on bus_rdata. A mode-set word and a bit set/reset word share one address, so they are interleaved back to back; the reference model then judges latches, enables and read data on every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_W      = 8;
  localparam int PIO_NIB    = PIO_W / 2;
  localparam int PIO_PORTS  = 3;
  localparam int PIO_GRP_W  = PIO_PORTS * PIO_W;
  localparam int PIO_GROUPS = 2;
  localparam int PIO_PINS   = PIO_GROUPS * PIO_GRP_W;

  // control word bit positions
  localparam int CB_MODE  = 7;
  localparam int CB_A_IN  = 4;
  localparam int CB_CH_IN = 3;
  localparam int CB_B_IN  = 1;
  localparam int CB_CL_IN = 0;

  localparam logic [PIO_W-1:0] CTRL_RESET = 8'h9B;

  typedef enum logic [1:0] {
    OFF_A   = 2'd0,
    OFF_B   = 2'd1,
    OFF_C   = 2'd2,
    OFF_CTL = 2'd3
  } pio_off_e;
endpackage

// File: rtl/pio_dir_decode.sv
module pio_dir_decode
  import pio_pkg::*;
(
  input  logic [PIO_W-1:0]     ctl,
  output logic [PIO_GRP_W-1:0] oe
);
  always_comb begin
    oe[PIO_W-1:0]                = {PIO_W{~ctl[CB_A_IN]}};
    oe[2*PIO_W-1:PIO_W]          = {PIO_W{~ctl[CB_B_IN]}};
    oe[2*PIO_W+PIO_NIB-1:2*PIO_W] = {PIO_NIB{~ctl[CB_CL_IN]}};
    oe[PIO_GRP_W-1:2*PIO_W+PIO_NIB] = {PIO_NIB{~ctl[CB_CH_IN]}};
  end
endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_off,
  input  logic [PIO_W-1:0]     wr_data,
  input  logic [1:0]           rd_off,
  input  logic [PIO_GRP_W-1:0] pin_in,
  output logic [PIO_GRP_W-1:0] lat_out,
  output logic [PIO_GRP_W-1:0] oe_out,
  output logic [PIO_W-1:0]     rd_val
);
  localparam int SEL_W = $clog2(PIO_W);

  logic [PIO_W-1:0]                  ctl_q, ctl_d;
  logic                              ctl_en;
  logic [PIO_PORTS-1:0][PIO_W-1:0]   lat_q, lat_d;
  logic                              lat_en;
  logic [PIO_PORTS-1:0][PIO_W-1:0]   oe_v, pin_v;

  always_comb begin
    ctl_d  = wr_data;
    ctl_en = wr_en && (wr_off == OFF_CTL) && wr_data[CB_MODE];
    lat_d  = lat_q;
    lat_en = wr_en;
    case (wr_off)
      OFF_A:   lat_d[0] = wr_data;
      OFF_B:   lat_d[1] = wr_data;
      OFF_C:   lat_d[2] = wr_data;
      default: begin
        if (wr_data[CB_MODE]) lat_d = '0;
        else lat_d[2][wr_data[SEL_W:1]] = wr_data[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTRL_RESET;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  pio_dir_decode u_dec (.ctl(ctl_q), .oe(oe_v));

  assign pin_v   = pin_in;
  assign lat_out = lat_q;
  assign oe_out  = oe_v;

  always_comb begin
    case (rd_off)
      OFF_A:   rd_val = (lat_q[0] & oe_v[0]) | (pin_v[0] & ~oe_v[0]);
      OFF_B:   rd_val = (lat_q[1] & oe_v[1]) | (pin_v[1] & ~oe_v[1]);
      OFF_C:   rd_val = (lat_q[2] & oe_v[2]) | (pin_v[2] & ~oe_v[2]);
      default: rd_val = ctl_q;
    endcase
  end
endmodule

// File: rtl/pio_read_reg.sv
module pio_read_reg
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [PIO_W-1:0] cap_d,
  output logic [PIO_W-1:0] cap_q
);
  logic [PIO_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (cap_en) q_r <= cap_d;
  end

  assign cap_q = q_r;
endmodule

// File: rtl/pio_dual.sv
module pio_dual
  import pio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [PIO_W-1:0]    bus_wdata,
  output logic [PIO_W-1:0]    bus_rdata,
  input  logic [PIO_PINS-1:0] pin_in,
  output logic [PIO_PINS-1:0] pin_out,
  output logic [PIO_PINS-1:0] pin_oe
);
  logic [PIO_GROUPS-1:0][PIO_W-1:0] grp_rd;
  logic [PIO_W-1:0]                 rd_sel;

  for (genvar g = 0; g < PIO_GROUPS; g++) begin : g_grp
    pio_group u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && (bus_addr[2] == g[0])),
      .wr_off  (bus_addr[1:0]),
      .wr_data (bus_wdata),
      .rd_off  (bus_addr[1:0]),
      .pin_in  (pin_in[g*PIO_GRP_W +: PIO_GRP_W]),
      .lat_out (pin_out[g*PIO_GRP_W +: PIO_GRP_W]),
      .oe_out  (pin_oe[g*PIO_GRP_W +: PIO_GRP_W]),
      .rd_val  (grp_rd[g])
    );
  end

  assign rd_sel = grp_rd[bus_addr[2]];

  pio_read_reg u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (bus_rd),
    .cap_d  (rd_sel),
    .cap_q  (bus_rdata)
  );
endmodule

// File: rtl/pio_dual_chk.sv
module pio_dual_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [47:0] pin_out,
  input logic [47:0] pin_oe
);
  // R3: mode-set on group 1 sets port A enable from bit 4
  a_r3_porta_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && bus_wdata[7]) |=> (pin_oe[7:0] == {8{~$past(bus_wdata[4])}}));

  // R6: mode-set on group 2 zeroes its latches
  a_r6_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd7 && bus_wdata[7]) |=> (pin_out[47:24] == 24'h0));

  // R4: port A write of group 1 lands in the latch
  a_r4_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> (pin_out[7:0] == $past(bus_wdata)));

  // R7: bit set/reset on group 1 port C
  a_r7_bit_setreset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && !bus_wdata[7])
      |=> (pin_out[16 + $past(bus_wdata[3:1])] == $past(bus_wdata[0])));

  // R5: each port C nibble has a uniform enable
  a_r5_nibble_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(pin_oe[19:16]) == 0 || $countones(pin_oe[19:16]) == 4) &&
     ($countones(pin_oe[23:20]) == 0 || $countones(pin_oe[23:20]) == 4) &&
     ($countones(pin_oe[43:40]) == 0 || $countones(pin_oe[43:40]) == 4) &&
     ($countones(pin_oe[47:44]) == 0 || $countones(pin_oe[47:44]) == 4)));

  // R9: read data holds without a read strobe
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R10: pins move only after a write
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind pio_dual pio_dual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pio_dual_bench.sv
module pio_dual_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in;
  logic [47:0] pin_out, pin_oe;

  int n_cmp  = 0;
  int n_fail = 0;

  logic [7:0] m_ctl [2];
  logic [7:0] m_lat [2][3];
  logic [7:0] m_rd;

  always #10 clk = ~clk;

  pio_dual u_pio_dual (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] oe_of(int g, int p);
    logic [7:0] c = m_ctl[g];
    if (p == 0) return c[4] ? 8'h00 : 8'hFF;
    if (p == 1) return c[1] ? 8'h00 : 8'hFF;
    return {(c[3] ? 4'h0 : 4'hF), (c[0] ? 4'h0 : 4'hF)};
  endfunction

  function automatic logic [7:0] pin_of(int g, int p);
    return pin_in[g*24 + p*8 +: 8];
  endfunction

  task automatic model_reset();
    for (int g = 0; g < 2; g++) begin
      m_ctl[g] = 8'h9B;
      for (int p = 0; p < 3; p++) m_lat[g][p] = 8'h00;
    end
    m_rd = 8'h00;
  endtask

  task automatic model_step(bit wr, bit rd, logic [2:0] a, logic [7:0] d);
    int g = a[2];
    int p = a[1:0];
    if (rd) begin
      if (p == 3) m_rd = m_ctl[g];
      else m_rd = (m_lat[g][p] & oe_of(g, p)) | (pin_of(g, p) & ~oe_of(g, p));
    end
    if (wr) begin
      if (p < 3) m_lat[g][p] = d;
      else if (d[7]) begin
        m_ctl[g] = d;
        for (int k = 0; k < 3; k++) m_lat[g][k] = 8'h00;
      end else m_lat[g][2][d[3:1]] = d[0];
    end
  endtask

  task automatic compare(string tag);
    logic [47:0] e_out, e_oe;
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 3; p++) begin
        e_out[g*24 + p*8 +: 8] = m_lat[g][p];
        e_oe[g*24 + p*8 +: 8]  = oe_of(g, p);
      end
    n_cmp += 3;
    if (pin_out !== e_out) begin
      n_fail++;
      $display("FAIL %s pin_out actual %h expected %h", tag, pin_out, e_out);
    end
    if (pin_oe !== e_oe) begin
      n_fail++;
      $display("FAIL %s pin_oe actual %h expected %h", tag, pin_oe, e_oe);
    end
    if (bus_rdata !== m_rd) begin
      n_fail++;
      $display("FAIL %s bus_rdata actual %h expected %h", tag, bus_rdata, m_rd);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [7:0] d, string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(wr, rd, a, d);
    @(negedge clk);
    compare(tag);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 48'hC3_5A_F0_0F_A5_96;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    // R1: reset state of controls and inputs read back
    cyc(0, 1, 3'd3, 8'h00, "R1");
    cyc(0, 1, 3'd7, 8'h00, "R1");
    cyc(0, 1, 3'd0, 8'h00, "R8");
    cyc(0, 1, 3'd6, 8'h00, "R8");
    // R4: latches load while ports are inputs
    cyc(1, 0, 3'd1, 8'h3C, "R4");
    // R3: directions from mode-set words
    cyc(1, 0, 3'd3, 8'h80, "R3");
    cyc(1, 0, 3'd7, 8'h90, "R3");
    cyc(1, 0, 3'd7, 8'h82, "R3");
    // R2/R4: each address to its own latch
    cyc(1, 0, 3'd0, 8'hA5, "R2");
    cyc(1, 0, 3'd1, 8'h3C, "R2");
    cyc(1, 0, 3'd2, 8'h5A, "R2");
    cyc(1, 0, 3'd4, 8'h11, "R2");
    cyc(1, 0, 3'd5, 8'h22, "R2");
    cyc(1, 0, 3'd6, 8'h33, "R2");
    // R8: readback mixes latch and pins
    for (int a = 0; a < 8; a++) cyc(0, 1, a[2:0], 8'h00, "R8");
    // R5: port C nibbles split both ways
    cyc(1, 0, 3'd3, 8'h88, "R5");
    cyc(1, 0, 3'd2, 8'hE7, "R5");
    cyc(0, 1, 3'd2, 8'h00, "R5");
    cyc(1, 0, 3'd3, 8'h81, "R5");
    cyc(1, 0, 3'd2, 8'hE7, "R5");
    cyc(0, 1, 3'd2, 8'h00, "R5");
    // R6: mode-set zeroes own group only
    cyc(1, 0, 3'd0, 8'hFF, "R6");
    cyc(1, 0, 3'd7, 8'h80, "R6");
    cyc(1, 0, 3'd4, 8'h77, "R6");
    cyc(1, 0, 3'd3, 8'h80, "R6");
    // R7: bit set/reset on port C
    cyc(1, 0, 3'd3, 8'h0F, "R7");
    cyc(1, 0, 3'd3, 8'h01, "R7");
    cyc(1, 0, 3'd7, 8'h0B, "R7");
    cyc(1, 0, 3'd3, 8'h0E, "R7");
    cyc(0, 1, 3'd3, 8'h00, "R7");
    // R9: same-cycle read and write see old state; data holds
    cyc(1, 1, 3'd0, 8'h5C, "R9");
    cyc(0, 0, 3'd0, 8'h00, "R9");
    cyc(1, 1, 3'd3, 8'h9B, "R9");
    cyc(1, 1, 3'd7, 8'h93, "R9");
    pin_in = 48'h0123_4567_89AB;
    cyc(0, 0, 3'd1, 8'h00, "R9");
    // R10: idle cycles keep pins still, pins change after writes only
    cyc(0, 0, 3'd2, 8'hFF, "R10");
    cyc(1, 0, 3'd6, 8'h99, "R10");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d = 8'($urandom);
      if ((i % 7) == 0) pin_in = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      cyc(1'($urandom), 1'($urandom), 3'($urandom), d, "R8");
    end
    summary();
  end
endmodule